// File: doc/BRIEF.md
# Configurable LUT Logic Slice

A model of one slice of a programmable logic fabric. The slice holds two identical logic cells. Each cell has a 4-input lookup table with 16 truth-table bits, a carry unit for addition and an output register that configuration can bypass. A per-cell mode field chooses how the table is used. It can act as a plain logic function or as the propagate term of an adder bit. It can also be a writable 16x1 memory with asynchronous read, or a 16-bit shift register with a selectable tap. A slice-level multiplexer picks one of the two cells' function outputs, so that with both tables fed the same inputs the slice forms a 5-input function.

All configuration lives in one serial scan chain of 38 bits, loaded MSB-first while `cfg_en` is high. The bit shifted out appears on `cfg_dout`, so slices can be daisy-chained. While loading, table writes, table shifts and register updates are suppressed. A synchronous reset clears only the output registers. Carry enters at `cin`, ripples through cell 0 into cell 1 and leaves at `cout`, so slices can be cascaded into wider adders.

The slice has no streamed data path. Every pin is a plain level signal sampled on the rising clock edge, so no valid/ready handshake applies and no back-pressure rules exist.

Top module: `fabric_slice`

## Requirements
- R1: In logic mode (mode 00) a cell's function output equals table bit T[a], where a is the cell's 4-bit input taken as an unsigned index.
- R2: The chain is 38 bits and shifts one bit per clock while `cfg_en` is 1. The stream carries cell 1 first and then cell 0. Each cell sends mode[1], mode[0], the register-select bit, then T[15] down to T[0]. `cfg_dout` shows the bit that entered 38 shifts earlier.
- R3: A cell whose register-select bit is 1 drives `q` from its register. When the bit is 0, `q` is the combinational function output.
- R4: On a rising edge with `rst`=1 the output registers clear, and configuration is left as it was. With `rst`=0, `ce`=1 and `cfg_en`=0, each register loads its cell's function output. Otherwise it holds.
- R5: In arithmetic mode (01) the table bit is the propagate p. The function output is p XOR carry-in, and carry-out is carry-in when p=1 and input bit a[0] when p=0. Cell 0 takes `cin`, cell 1 takes cell 0's carry-out, and `cout` is cell 1's carry-out.
- R6: A cell in any mode other than arithmetic passes its carry-in unchanged to its carry-out.
- R7: In RAM mode (10) a rising edge with the cell's `wr_en`=1 writes its `wr_data` to T[a], and the function output reads T[a] with no clock delay.
- R8: In shift mode (11) a rising edge with `wr_en`=1 shifts the table up one place and puts `wr_data` into T[0]. The function output is tap T[a].
- R9: In logic and arithmetic modes `wr_en` and `wr_data` leave the table unchanged.
- R10: While `cfg_en` is 1, `wr_en` has no effect on the table beyond the scan shift, and the output registers hold unless `rst` is 1.
- R11: `f_mux` equals cell 0's function output when `sel`=0 and cell 1's when `sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear of the output registers |
| cfg_en | input | 1 | Scan chain shift enable |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Serial configuration output for chaining |
| lut_in | input | 8 | Table inputs, cell i at bits [4i+3:4i] |
| wr_en | input | 2 | Per-cell write or shift enable |
| wr_data | input | 2 | Per-cell write data or serial shift input |
| ce | input | 1 | Output register clock enable |
| cin | input | 1 | Carry into cell 0 |
| cout | output | 1 | Carry out of cell 1 |
| sel | input | 1 | Slice mux select |
| q | output | 2 | Per-cell output, registered or combinational |
| f_mux | output | 1 | Slice mux output |

## Verification
Any wrong table bit, mode bit or register-select bit shows up at the ports as soon as the input pattern addresses it. It also appears on `cfg_dout` exactly when that bit reaches the end of the scan chain, which a shadow image of the chain checks bit for bit. A register that captures at the wrong time, or that misses a reset, differs from the expected `q` on the very next sample after the faulty edge. A wrong carry path shows on `cout` in the same cycle as the inputs that exercise it. Because the bench compares every output against its model each cycle, a corrupted RAM write or table shift becomes visible on the first later read of that address.

// File: rtl/slice_pkg.sv
package slice_pkg;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'b00,
    MODE_ARITH = 2'b01,
    MODE_RAM   = 2'b10,
    MODE_SHIFT = 2'b11
  } cell_mode_e;

  localparam int DEF_LUT_K = 4;
  localparam int DEF_CELLS = 2;
  localparam int MODE_W    = 2;

  // configuration bits carried per cell besides the table itself
  localparam int CELL_EXTRA_BITS = MODE_W + 1;

  function automatic int table_bits(input int k);
    return 1 << k;
  endfunction

  function automatic int cell_cfg_bits(input int k);
    return table_bits(k) + CELL_EXTRA_BITS;
  endfunction

endpackage

// File: rtl/lut_store.sv
module lut_store
  import slice_pkg::*;
#(
  parameter int K = DEF_LUT_K
) (
  input  logic         clk,
  input  logic         cfg_en,
  input  logic         scan_in,
  output logic         scan_out,
  input  logic [K-1:0] addr,
  input  logic         wr_en,
  input  logic         wr_data,
  output logic         lut_bit,
  output cell_mode_e   mode,
  output logic         use_reg
);

  localparam int TW = table_bits(K);

  logic [TW-1:0]     tbl;
  logic [MODE_W-1:0] mode_q;
  logic              ureg_q;

  assign mode     = cell_mode_e'(mode_q);
  assign use_reg  = ureg_q;
  assign scan_out = mode_q[MODE_W-1];
  assign lut_bit  = tbl[addr];

  always_ff @(posedge clk) begin
    if (cfg_en) begin
      {mode_q, ureg_q, tbl} <= {mode_q[MODE_W-2:0], ureg_q, tbl, scan_in};
    end else if (wr_en) begin
      unique case (mode)
        MODE_RAM:   tbl[addr] <= wr_data;
        MODE_SHIFT: tbl       <= {tbl[TW-2:0], wr_data};
        default:    tbl       <= tbl;
      endcase
    end
  end

endmodule

// File: rtl/carry_unit.sv
module carry_unit
  import slice_pkg::*;
(
  input  cell_mode_e mode,
  input  logic       prop,
  input  logic       gen,
  input  logic       ci,
  output logic       f,
  output logic       co,
  output logic       is_arith
);

  always_comb begin
    is_arith = (mode == MODE_ARITH);
    if (is_arith) begin
      f  = prop ^ ci;
      co = prop ? ci : gen;
    end else begin
      f  = prop;
      co = ci;
    end
  end

endmodule

// File: rtl/out_reg.sv
module out_reg (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic hold,
  input  logic d,
  input  logic use_reg,
  output logic r,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      r <= 1'b0;
    end else if (ce && !hold) begin
      r <= d;
    end
  end

  assign q = use_reg ? r : d;

endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import slice_pkg::*;
#(
  parameter int K = DEF_LUT_K
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         cfg_en,
  input  logic         scan_in,
  output logic         scan_out,
  input  logic [K-1:0] addr,
  input  logic         wr_en,
  input  logic         wr_data,
  input  logic         ci,
  output logic         co,
  output logic         f,
  output logic         r,
  output logic         q,
  output logic         is_arith
);

  cell_mode_e mode;
  logic       lut_bit;
  logic       use_reg;

  lut_store #(.K(K)) u_store (
    .clk      (clk),
    .cfg_en   (cfg_en),
    .scan_in  (scan_in),
    .scan_out (scan_out),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .lut_bit  (lut_bit),
    .mode     (mode),
    .use_reg  (use_reg)
  );

  carry_unit u_carry (
    .mode     (mode),
    .prop     (lut_bit),
    .gen      (addr[0]),
    .ci       (ci),
    .f        (f),
    .co       (co),
    .is_arith (is_arith)
  );

  out_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .hold    (cfg_en),
    .d       (f),
    .use_reg (use_reg),
    .r       (r),
    .q       (q)
  );

endmodule

// File: rtl/fabric_slice.sv
module fabric_slice
  import slice_pkg::*;
#(
  parameter  int K     = DEF_LUT_K,
  parameter  int NCELL = DEF_CELLS,
  localparam int SEL_W = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_en,
  input  logic               cfg_din,
  output logic               cfg_dout,
  input  logic [NCELL*K-1:0] lut_in,
  input  logic [NCELL-1:0]   wr_en,
  input  logic [NCELL-1:0]   wr_data,
  input  logic               ce,
  input  logic               cin,
  output logic               cout,
  input  logic [SEL_W-1:0]   sel,
  output logic [NCELL-1:0]   q,
  output logic               f_mux
);

  logic [NCELL:0]   carry;
  logic [NCELL:0]   scan;
  logic [NCELL-1:0] cell_f;
  logic [NCELL-1:0] cell_r;
  logic [NCELL-1:0] cell_arith;

  assign carry[0] = cin;
  assign scan[0]  = cfg_din;
  assign cout     = carry[NCELL];
  assign cfg_dout = scan[NCELL];

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic_cell #(.K(K)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .ce       (ce),
      .cfg_en   (cfg_en),
      .scan_in  (scan[i]),
      .scan_out (scan[i+1]),
      .addr     (lut_in[i*K +: K]),
      .wr_en    (wr_en[i]),
      .wr_data  (wr_data[i]),
      .ci       (carry[i]),
      .co       (carry[i+1]),
      .f        (cell_f[i]),
      .r        (cell_r[i]),
      .q        (q[i]),
      .is_arith (cell_arith[i])
    );
  end

  always_comb begin
    f_mux = 1'b0;
    for (int i = 0; i < NCELL; i++) begin
      if (int'(sel) == i) f_mux = cell_f[i];
    end
  end

endmodule

// File: rtl/slice_checker.sv
module slice_checker #(
  parameter int NCELL = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             ce,
  input logic             cin,
  input logic             cout,
  input logic [NCELL-1:0] cell_f,
  input logic [NCELL-1:0] cell_r,
  input logic [NCELL-1:0] cell_arith
);

  logic rst_seen;

  always_ff @(posedge clk) rst_seen <= rst;

  // R4: the edge after a reset cycle leaves every register cleared
  assert_reset_clears_R4: assert property (@(posedge clk) disable iff (rst)
    rst_seen |-> (cell_r == '0));

  // R4: enabled capture takes the function value present at the edge
  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (ce && !cfg_en) |=> (cell_r == $past(cell_f)));

  // R4: without clock enable the registers keep their value
  assert_ce_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(cell_r));

  // R10: loading configuration freezes the registers
  assert_load_hold_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> $stable(cell_r));

  // R6: with no arithmetic cell the carry passes straight through
  assert_carry_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (cell_arith == '0) |-> (cout == cin));

endmodule

bind fabric_slice slice_checker #(.NCELL(NCELL)) u_slice_checker (
  .clk        (clk),
  .rst        (rst),
  .cfg_en     (cfg_en),
  .ce         (ce),
  .cin        (cin),
  .cout       (cout),
  .cell_f     (cell_f),
  .cell_r     (cell_r),
  .cell_arith (cell_arith)
);

// File: tb/fabric_slice_test.sv
module fabric_slice_test;

  localparam int K  = 4;
  localparam int NC = 2;
  localparam int TW = 16;
  localparam int FW = 19;
  localparam int CW = NC * FW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_en = 1'b0;
  logic          cfg_din = 1'b0;
  logic          cfg_dout;
  logic [NC*K-1:0] lut_in = '0;
  logic [NC-1:0] wr_en = '0;
  logic [NC-1:0] wr_data = '0;
  logic          ce = 1'b0;
  logic          cin = 1'b0;
  logic          cout;
  logic          sel = 1'b0;
  logic [NC-1:0] q;
  logic          f_mux;

  always #4 clk = ~clk;

  fabric_slice #(.K(K), .NCELL(NC)) uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .lut_in(lut_in), .wr_en(wr_en),
    .wr_data(wr_data), .ce(ce), .cin(cin), .cout(cout), .sel(sel),
    .q(q), .f_mux(f_mux)
  );

  // reference state: chain image, cell i field at [i*FW +: FW]
  // field = {mode[1:0], register select, table[15:0]}
  logic [CW-1:0] mv = '0;
  logic [NC-1:0] mreg = '0;
  int            shifts = 0;
  bit            prev_cfg = 0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  function automatic void eval(output logic [NC-1:0] f, output logic co);
    logic c;
    c = cin;
    for (int i = 0; i < NC; i++) begin
      logic [FW-1:0] fd;
      logic [K-1:0]  a;
      logic          p;
      fd = mv[i*FW +: FW];
      a  = lut_in[i*K +: K];
      p  = fd[a];
      if (fd[FW-1 -: 2] == 2'b01) begin
        f[i] = p ^ c;
        c    = p ? c : a[0];
      end else begin
        f[i] = p;
      end
    end
    co = c;
  endfunction

  always @(posedge clk) begin
    logic [NC-1:0] fe;
    logic          ce_out;
    eval(fe, ce_out);
    if (rst) mreg = '0;
    else if (ce && !cfg_en) mreg = fe;
    if (cfg_en) begin
      mv = {mv[CW-2:0], cfg_din};
      if (shifts < CW) shifts++;
    end else begin
      for (int i = 0; i < NC; i++) begin
        logic [1:0]   md;
        logic [K-1:0] a;
        md = mv[i*FW + FW - 1 -: 2];
        a  = lut_in[i*K +: K];
        if (wr_en[i] && md == 2'b10) mv[i*FW + int'(a)] = wr_data[i];
        if (wr_en[i] && md == 2'b11)
          mv[i*FW +: TW] = {mv[i*FW +: TW-1], wr_data[i]};
      end
    end
    prev_cfg = cfg_en;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [NC-1:0] fe;
    logic          co;
    if (shifts < CW) return;
    eval(fe, co);
    for (int i = 0; i < NC; i++) begin
      logic [1:0] md;
      logic       ur;
      string      tag;
      md = mv[i*FW + FW - 1 -: 2];
      ur = mv[i*FW + TW];
      if (prev_cfg) tag = "R10";
      else if (ur) tag = "R3/R4";
      else if (md == 2'b00) tag = "R1/R9";
      else if (md == 2'b01) tag = "R5/R9";
      else if (md == 2'b10) tag = "R7";
      else tag = "R8";
      chk($sformatf("%s q[%0d]", tag, i), q[i], ur ? mreg[i] : fe[i]);
    end
    chk("R11 f_mux", f_mux, fe[sel]);
    chk((uut.cell_arith != '0) ? "R5 cout" : "R6 cout", cout, co);
    chk("R2 cfg_dout", cfg_dout, mv[CW-1]);
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  function automatic logic [CW-1:0] image(
      input logic [1:0] m1, input logic u1, input logic [TW-1:0] t1,
      input logic [1:0] m0, input logic u0, input logic [TW-1:0] t0);
    return {m1, u1, t1, m0, u0, t0};
  endfunction

  task automatic load(input logic [CW-1:0] img);
    for (int i = CW - 1; i >= 0; i--) begin
      cfg_en  = 1'b1;
      cfg_din = img[i];
      wr_en   = NC'($urandom);
      tick();
    end
    cfg_en = 1'b0;
  endtask

  task automatic run(input int n, input bit allow_cfg);
    for (int i = 0; i < n; i++) begin
      lut_in  = NC*K'($urandom);
      wr_en   = NC'($urandom);
      wr_data = NC'($urandom);
      ce      = ($urandom % 4) != 0;
      cin     = 1'($urandom);
      sel     = 1'($urandom);
      rst     = ($urandom % 40) == 0;
      cfg_en  = allow_cfg && (($urandom % 25) == 0);
      cfg_din = 1'($urandom);
      tick();
    end
    rst    = 1'b0;
    cfg_en = 1'b0;
  endtask

  // sweep every address on both cells with fixed control
  task automatic sweep(input logic write);
    for (int a = 0; a < TW; a++) begin
      lut_in  = {K'(a), K'(TW - 1 - a)};
      wr_en   = {NC{write}};
      wr_data = NC'(a);
      ce      = 1'b1;
      cin     = 1'(a >> 1);
      sel     = 1'(a);
      tick();
    end
    wr_en = '0;
  endtask

  initial begin
    // first load with reset held so registers start cleared
    rst = 1'b1;
    load(image(2'b00, 1'b0, 16'h6996, 2'b01, 1'b1, 16'h6666));
    tick();
    rst = 1'b0;
    tick();
    // R4: registered cell reads zero right after reset
    chk("R4 reset q[0]", q[0], 1'b0);
    sweep(1'b1);            // R9: writes ignored in logic and arithmetic
    run(300, 1'b0);
    // R7 and R8: memory on cell 0, shift register on cell 1
    load(image(2'b11, 1'b1, 16'h0f0f, 2'b10, 1'b0, 16'h1234));
    sweep(1'b1);
    sweep(1'b0);
    run(400, 1'b1);
    // R5: two-bit ripple adder, both arithmetic, combinational
    load(image(2'b01, 1'b0, 16'h6666, 2'b01, 1'b0, 16'h6666));
    sweep(1'b1);
    run(300, 1'b0);
    // mixed modes with registered outputs
    load(image(2'b01, 1'b1, 16'h8ff1, 2'b00, 1'b1, 16'hbeef));
    run(400, 1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule